// File: doc/BRIEF.md
# Host Write Port Front End

This block receives write transfers from a microprocessor and turns each completed transfer into one byte on a system-clock stream. The byte comes with a flag that says whether it is a command or display data. One 8-bit host bus serves four ways of writing:

- a two-wire serial port that uses two of the bus lines;
- a full-byte parallel port;
- a nibble-wide parallel port;
- either strobe convention for the parallel ports: an active-low write strobe, or an active-high enable clock.

Every host pin is asynchronous to the system clock. Each one passes through a two-flop synchronizer, and host strobes and clocks are found by comparing the synchronized value with its value one cycle earlier. The system clock must run at least four times faster than the fastest host strobe or serial clock. Each host level must be held for at least two system cycles.

The host reset pin is edge-sensitive. Either edge abandons any partly received byte. The level the pin settles to then picks the strobe convention. The output side has no ready input and cannot push back on the host. A consumer must accept each valid pulse in the cycle it appears. The byte and flag stay on the outputs until the next pulse, so a slow consumer may read them later.

Top module: `host_bus_front`

## Requirements
- R1: After system reset, out_valid_o is 0, out_byte_o is 0x00 and out_is_data_o is 0. The strobe convention starts as enable-clock style.
- R2: With par_sel_i low the port is serial. bus_i[7] is serial data and bus_i[6] is the serial clock. Bits shift in MSB first on each synchronized rising edge of the serial clock, and a byte is output after the eighth bit.
- R3: out_is_data_o copies rs_i as it is sampled with the completing transfer: the eighth serial bit or the final parallel strobe. 0 marks a command and 1 marks display data.
- R4: While cs_n_i is high no byte is produced. Deasserting cs_n_i also clears the serial bit count and the nibble phase, so the next transfer starts a fresh byte.
- R5: In write-strobe style (host reset pin last settled high), the parallel bus is captured on the rising edge of wr_i. A falling edge of wr_i captures nothing.
- R6: In enable-clock style (host reset pin last settled low), the parallel bus is captured on the falling edge of wr_i. A rising edge of wr_i captures nothing.
- R7: Any edge on hst_reset_i discards a partial serial or nibble transfer. The new level selects the strobe convention: 0 selects enable-clock style and 1 selects write-strobe style.
- R8: In parallel mode with wide_i high, each capture outputs bus_i[7:0] as one byte.
- R9: In parallel mode with wide_i low, only bus_i[7:4] is used. Two captures form one byte, with the first capture as bits 7:4 and the second as bits 3:0.
- R10: out_valid_o is high for exactly one cycle per byte. out_byte_o and out_is_data_o change only in a cycle where out_valid_o is high.
- R11: A host edge applied between two system clock edges produces out_valid_o after the third following system clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| hst_reset_i | input | 1 | Host reset pin; an edge restarts, the level picks the strobe style |
| par_sel_i | input | 1 | 1 = parallel, 0 = serial |
| wide_i | input | 1 | Parallel width: 1 = 8-bit, 0 = 4-bit |
| cs_n_i | input | 1 | Chip select, active low |
| rs_i | input | 1 | Register select: 0 = command, 1 = display data |
| wr_i | input | 1 | Write strobe or enable clock |
| bus_i | input | 8 | Host data bus; bits 7 and 6 carry serial data and serial clock |
| out_valid_o | output | 1 | One-cycle byte strobe |
| out_byte_o | output | 8 | Received byte |
| out_is_data_o | output | 1 | Flag that travels with the byte |

## Verification
A wrong bit count or nibble phase shows up as a shifted or merged byte at the very next output pulse. It also shows up as an extra or missing pulse after a chip-select gap or a host reset edge. A wrong strobe style makes a pulse appear one strobe half-period early or late, or not at all. The bench's reference model compares valid, byte and flag on every system cycle, so each of these faults is caught in the cycle where the first output differs.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  localparam int BYTE_W   = 8;
  localparam int NIB_W    = BYTE_W / 2;
  localparam int SDI_BIT  = 7;
  localparam int SCLK_BIT = 6;

  typedef enum logic {STYLE_ENABLE = 1'b0, STYLE_STROBE = 1'b1} bus_style_e;

  typedef struct packed {
    logic              host_rst;
    logic              par_sel;
    logic              wide;
    logic              cs_n;
    logic              rs;
    logic              strobe;
    logic [BYTE_W-1:0] data;
  } host_in_t;

  localparam int HOST_W = $bits(host_in_t);
endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= '0;
        else        r <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= '0;
        else        r <= g_stage[g-1].r;
    end
  end
  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/hbf_serial.sv
module hbf_serial
  import hbf_pkg::*;
#(
  parameter int CW = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic              sdi,
  input  logic              rs,
  output logic              fire,
  output logic [BYTE_W-1:0] byte_o,
  output logic              flag_o,
  output logic [CW-1:0]     cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg;
  logic [CW-1:0]     cnt;

  assign byte_o = {shreg[BYTE_W-2:0], sdi};
  assign flag_o = rs;
  assign fire   = shift && (cnt == LAST);
  assign cnt_o  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (clr) begin
      cnt   <= '0;
    end else if (shift) begin
      shreg <= byte_o;
      cnt   <= fire ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbf_parallel.sv
module hbf_parallel
  import hbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              evt,
  input  logic              wide,
  input  logic [BYTE_W-1:0] data,
  input  logic              rs,
  output logic              fire,
  output logic [BYTE_W-1:0] byte_o,
  output logic              flag_o,
  output logic              phase_o
);
  logic              phase;
  logic [NIB_W-1:0]  hi_nib;
  logic [NIB_W-1:0]  nib;

  assign nib     = data[BYTE_W-1 -: NIB_W];
  assign fire    = evt && (wide || phase);
  assign byte_o  = wide ? data : {hi_nib, nib};
  assign flag_o  = rs;
  assign phase_o = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 1'b0;
      hi_nib <= '0;
    end else if (clr) begin
      phase  <= 1'b0;
    end else if (evt && !wide) begin
      if (!phase) begin
        hi_nib <= nib;
        phase  <= 1'b1;
      end else begin
        phase  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/host_bus_front.sv
module host_bus_front
  import hbf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_reset_i,
  input  logic              par_sel_i,
  input  logic              wide_i,
  input  logic              cs_n_i,
  input  logic              rs_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] bus_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              out_is_data_o
);
  localparam int CW = $clog2(BYTE_W);

  host_in_t   raw, syn;
  logic       prv_rst, prv_sclk, prv_strb;
  bus_style_e style_q;

  assign raw = '{host_rst: hst_reset_i, par_sel: par_sel_i, wide: wide_i,
                 cs_n: cs_n_i, rs: rs_i, strobe: wr_i, data: bus_i};

  hbf_sync #(.W(HOST_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_rst  <= 1'b0;
      prv_sclk <= 1'b0;
      prv_strb <= 1'b0;
    end else begin
      prv_rst  <= syn.host_rst;
      prv_sclk <= syn.data[SCLK_BIT];
      prv_strb <= syn.strobe;
    end
  end

  logic rst_evt, clr, active, sclk_rise, strb_rise, strb_fall, cap_edge;
  assign rst_evt   = syn.host_rst ^ prv_rst;
  assign clr       = rst_evt || syn.cs_n;
  assign active    = !clr;
  assign sclk_rise = syn.data[SCLK_BIT] && !prv_sclk;
  assign strb_rise = syn.strobe && !prv_strb;
  assign strb_fall = !syn.strobe && prv_strb;
  assign cap_edge  = (style_q == STYLE_STROBE) ? strb_rise : strb_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       style_q <= STYLE_ENABLE;
    else if (rst_evt) style_q <= bus_style_e'(syn.host_rst);

  logic              ser_fire, par_fire, ser_flag, par_flag, par_phase;
  logic [BYTE_W-1:0] ser_byte, par_byte;
  logic [CW-1:0]     ser_cnt;

  hbf_serial #(.CW(CW)) u_serial (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .shift(active && !syn.par_sel && sclk_rise),
    .sdi(syn.data[SDI_BIT]), .rs(syn.rs),
    .fire(ser_fire), .byte_o(ser_byte), .flag_o(ser_flag), .cnt_o(ser_cnt)
  );

  hbf_parallel u_parallel (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .evt(active && syn.par_sel && cap_edge),
    .wide(syn.wide), .data(syn.data), .rs(syn.rs),
    .fire(par_fire), .byte_o(par_byte), .flag_o(par_flag), .phase_o(par_phase)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o   <= 1'b0;
      out_byte_o    <= '0;
      out_is_data_o <= 1'b0;
    end else begin
      out_valid_o <= ser_fire || par_fire;
      if (ser_fire) begin
        out_byte_o    <= ser_byte;
        out_is_data_o <= ser_flag;
      end else if (par_fire) begin
        out_byte_o    <= par_byte;
        out_is_data_o <= par_flag;
      end
    end
  end
endmodule

// File: rtl/host_bus_front_chk.sv
module host_bus_front_chk #(
  parameter int BW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic [BW-1:0] out_byte,
  input logic          out_flag,
  input logic          rst_evt,
  input logic          rst_lvl,
  input logic          style,
  input logic          cs_n_s,
  input logic [CW-1:0] ser_cnt,
  input logic          par_phase
);
  p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_byte) && $stable(out_flag)));

  p_cs_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (ser_cnt == '0 && !par_phase));

  p_cs_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$past(cs_n_s));

  p_rst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> !out_valid);

  p_style_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (style == $past(rst_lvl)));
endmodule

bind host_bus_front host_bus_front_chk #(.BW(hbf_pkg::BYTE_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid_o), .out_byte(out_byte_o), .out_flag(out_is_data_o),
  .rst_evt(rst_evt), .rst_lvl(syn.host_rst), .style(style_q),
  .cs_n_s(syn.cs_n), .ser_cnt(ser_cnt), .par_phase(par_phase)
);

// File: tb/test_host_bus_front.sv
module test_host_bus_front;
  import hbf_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  host_in_t drv;
  logic out_valid;
  logic [7:0] out_byte;
  logic out_flag;

  host_bus_front i_host_bus_front (
    .clk(clk), .rst_n(rst_n),
    .hst_reset_i(drv.host_rst), .par_sel_i(drv.par_sel), .wide_i(drv.wide),
    .cs_n_i(drv.cs_n), .rs_i(drv.rs), .wr_i(drv.strobe), .bus_i(drv.data),
    .out_valid_o(out_valid), .out_byte_o(out_byte), .out_is_data_o(out_flag)
  );

  int tests = 0, fails = 0, nbytes = 0, cyc = 0;
  logic [7:0] last_byte = '0;
  logic last_flag = 1'b0;
  string cur_req = "R1";
  logic sty = 1'b0;

  // behavioural reference model
  host_in_t h1, h2, h3;
  int m_cnt = 0, m_phase = 0, m_sty = 0;
  logic [7:0] m_sh = '0;
  logic [3:0] m_hi = '0;
  logic e_valid = 1'b0, e_flag = 1'b0;
  logic [7:0] e_byte = '0;

  function automatic void check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endfunction

  always @(posedge clk) begin
    e_valid = 1'b0;
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0;
      m_cnt = 0; m_phase = 0; m_sty = 0; m_sh = '0;
      e_byte = '0; e_flag = 1'b0;
    end else begin
      if (h2.host_rst != h3.host_rst) begin
        m_sty = int'(h2.host_rst); m_cnt = 0; m_phase = 0;
      end else if (h2.cs_n) begin
        m_cnt = 0; m_phase = 0;
      end else if (!h2.par_sel) begin
        if (h2.data[6] && !h3.data[6]) begin
          m_sh = {m_sh[6:0], h2.data[7]};
          m_cnt++;
          if (m_cnt == 8) begin
            e_valid = 1'b1; e_byte = m_sh; e_flag = h2.rs; m_cnt = 0;
          end
        end
      end else if ((m_sty == 1) ? (h2.strobe && !h3.strobe) : (!h2.strobe && h3.strobe)) begin
        if (h2.wide) begin
          e_valid = 1'b1; e_byte = h2.data; e_flag = h2.rs;
        end else if (m_phase == 0) begin
          m_hi = h2.data[7:4]; m_phase = 1;
        end else begin
          e_valid = 1'b1; e_byte = {m_hi, h2.data[7:4]}; e_flag = h2.rs; m_phase = 0;
        end
      end
      h3 = h2; h2 = h1; h1 = drv;
    end
    #1;
    if (rst_n) begin
      tests++;
      if (out_valid !== e_valid || out_byte !== e_byte || out_flag !== e_flag) begin
        fails++;
        $display("FAIL %s: actual v=%b b=%h f=%b expected v=%b b=%h f=%b", cur_req,
                 out_valid, out_byte, out_flag, e_valid, e_byte, e_flag);
      end
      if (out_valid) begin
        nbytes++; last_byte = out_byte; last_flag = out_flag;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bits(logic [7:0] b, int n, logic a0);
    drv.rs = a0;
    for (int i = 7; i > 7 - n; i--) begin
      drv.data[7] = b[i]; drv.data[6] = 1'b0; tick(3);
      drv.data[6] = 1'b1; tick(3);
    end
    drv.data[6] = 1'b0; tick(4);
  endtask

  task automatic par_write(logic [7:0] b, logic a0);
    drv.data = b; drv.rs = a0; tick(3);
    drv.strobe = ~sty; tick(4);
    drv.strobe = sty; tick(5);
  endtask

  task automatic expect_byte(string req, int n0, logic [7:0] b, logic f);
    check(req, nbytes, n0 + 1);
    check(req, last_byte, b);
    check(req, last_flag, f);
  endtask

  initial begin
    int n0;
    drv = '{host_rst: 1'b0, par_sel: 1'b0, wide: 1'b1, cs_n: 1'b1, rs: 1'b0,
            strobe: 1'b0, data: 8'h00};
    tick(5);
    rst_n = 1'b1;
    tick(1);
    cur_req = "R1";
    check("R1", out_valid, 0); check("R1", out_byte, 0); check("R1", out_flag, 0);
    tick(4);

    // serial transfers
    cur_req = "R2"; drv.cs_n = 1'b0; tick(4);
    n0 = nbytes; ser_bits(8'hA5, 8, 1'b0); expect_byte("R2", n0, 8'hA5, 1'b0);
    cur_req = "R3";
    n0 = nbytes; ser_bits(8'h3C, 8, 1'b1); expect_byte("R3", n0, 8'h3C, 1'b1);
    // partial byte then chip select gap
    cur_req = "R4";
    ser_bits(8'hE0, 3, 1'b0); drv.cs_n = 1'b1; tick(6);
    n0 = nbytes; ser_bits(8'hFF, 8, 1'b0); check("R4", nbytes, n0);
    drv.cs_n = 1'b0; tick(4);
    n0 = nbytes; ser_bits(8'h81, 8, 1'b1); expect_byte("R4", n0, 8'h81, 1'b1);

    // parallel enable-clock style, wide
    cur_req = "R8"; drv.par_sel = 1'b1; drv.wide = 1'b1; tick(6);
    n0 = nbytes; par_write(8'h5A, 1'b1); expect_byte("R8", n0, 8'h5A, 1'b1);
    cur_req = "R11";
    drv.data = 8'hC7; drv.rs = 1'b0; tick(3); drv.strobe = 1'b1; tick(4);
    drv.strobe = 1'b0; tick(2); check("R11", out_valid, 0);
    tick(1); check("R11", out_valid, 1); check("R6", out_byte, 8'hC7);
    tick(1); check("R10", out_valid, 0);
    tick(6); check("R10", out_byte, 8'hC7); check("R10", out_flag, 0);
    cur_req = "R6";
    n0 = nbytes; drv.data = 8'h11; drv.strobe = 1'b1; tick(8); check("R6", nbytes, n0);

    // switch to write-strobe style by host reset edge
    cur_req = "R7"; drv.host_rst = 1'b1; sty = 1'b1; tick(6);
    cur_req = "R5";
    n0 = nbytes; par_write(8'hC3, 1'b1); expect_byte("R5", n0, 8'hC3, 1'b1);

    // nibble mode
    cur_req = "R9"; drv.wide = 1'b0; tick(6);
    n0 = nbytes; par_write(8'h9B, 1'b0); check("R9", nbytes, n0);
    par_write(8'hE4, 1'b1); expect_byte("R9", n0, 8'h9E, 1'b1);
    cur_req = "R4";
    par_write(8'h50, 1'b0); drv.cs_n = 1'b1; tick(6); drv.cs_n = 1'b0; tick(4);
    n0 = nbytes; par_write(8'h20, 1'b1); par_write(8'h6F, 1'b0);
    expect_byte("R4", n0, 8'h26, 1'b0);
    cur_req = "R7";
    par_write(8'hF0, 1'b0);
    n0 = nbytes; drv.strobe = 1'b0; tick(6); check("R5", nbytes, n0);
    drv.host_rst = 1'b0; sty = 1'b0; tick(6); check("R7", nbytes, n0);
    par_write(8'h1A, 1'b1); par_write(8'h7B, 1'b1);
    expect_byte("R7", n0, 8'h17, 1'b1);

    tick(10);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule